// File: doc/BRIEF.md
# PCIe Link Bring-Up Speed Sequencer

This block brings up a PCIe root-port link in two stages. A start pulse caps the advertised maximum link speed at Gen1 and enables the link training state machine. The block then polls the link until it reports up with training finished. Once that happens, it raises the speed cap to Gen2 and issues a directed speed-change request. It waits for the partner logic to clear a pending flag, and then polls the link once more to confirm that retraining has settled.

Every wait has a bounded number of polls at a fixed spacing. A link that reports up but is still training gets a few short rechecks before the poll counts as a miss. If any wait runs out of polls, the block starts a recovery: it asserts the two receiver override controls (data enable and PLL enable) for a fixed hold time, then releases them and reports failure. Separately, a registered flag reports a stuck Gen2 transition. This is the case where, at Gen2, the LTSSM sits in recovery receiver lock (state code 0x0D) while the receiver has no valid signal.

All delays and counts are parameters in clock cycles. The inputs are plain levels sampled on the clock.

Top module: `pcie_speed_seq`

## Requirements
- R1: After reset, `max_speed_o` is 1, and `ltssm_en_o`, `spd_req_o`, both override outputs, `stuck_o`, `done_o` and `fail_o` are all 0.
- R2: A start pulse seen in idle sets `max_speed_o` to 1 and `ltssm_en_o` to 1 at that clock edge. The first link poll samples the inputs at the next edge.
- R3: A link poll counts as up only when `link_up_i`=1 and `in_train_i`=0. If `link_up_i`=1 and `in_train_i`=1, the poll is retaken up to TRAIN_RETRY more times, RETRY_GAP+1 cycles apart. If training is still set after the last retake, or if `link_up_i`=0, the poll is a miss.
- R4: After a miss, the next link poll comes POLL_GAP+1 cycles later. A miss on poll number POLL_MAX is a failure.
- R5: At the edge of the first successful link poll, `max_speed_o` becomes 2 and `spd_req_o` becomes 1. `spd_pend_i` is first sampled POLL_GAP+1 cycles later, then every POLL_GAP+1 cycles, up to POLL_MAX samples. Sampling it at 0 completes the change and drops `spd_req_o`.
- R6: A second link wait, with the same rules as R3 and R4, starts one cycle after the speed change completes. Its success raises `done_o`, keeps `ltssm_en_o` at 1 and keeps `max_speed_o` at 2.
- R7: On failure, `rx_ovrd_data_o` and `rx_ovrd_pll_o` are both 1 for exactly RXRST_HOLD cycles. They fall in the same edge that raises `fail_o` and clears `ltssm_en_o` and `spd_req_o`.
- R8: `stuck_o` is 1 one cycle after a cycle in which `ltssm_en_o`=1, `max_speed_o`=2, `ltssm_state_i`=0x0D and `rx_valid_i`=0. Otherwise it is 0.
- R9: `done_o` and `fail_o` are single-cycle pulses and are never high together. A start pulse while a bring-up is in progress has no effect on its timing or outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a bring-up (accepted in idle only) |
| link_up_i | input | 1 | Link reports up |
| in_train_i | input | 1 | Link is still training |
| spd_pend_i | input | 1 | Directed speed change still pending |
| ltssm_state_i | input | 6 | Current LTSSM state code |
| rx_valid_i | input | 1 | Receiver valid indication |
| max_speed_o | output | SPD_W | Advertised maximum link speed |
| ltssm_en_o | output | 1 | Link training enable |
| spd_req_o | output | 1 | Directed speed-change request |
| rx_ovrd_data_o | output | 1 | Receiver data-enable override |
| rx_ovrd_pll_o | output | 1 | Receiver PLL-enable override |
| stuck_o | output | 1 | Gen2 transition appears stuck |
| done_o | output | 1 | Bring-up succeeded (pulse) |
| fail_o | output | 1 | Bring-up failed (pulse) |

## Verification
The bench sweeps three independent timelines under a short configuration:
- the cycle in which link-up appears,
- the cycle in which training clears,
- the cycle in which the speed-change pending flag clears.

Each combination is checked against the completion or failure edge predicted arithmetically. Varying the link-up cycle separates success on each poll from poll exhaustion. Varying the training-clear cycle separates success on a retake from a miss after all retakes, in both the first and the second wait. Varying the pending-clear cycle separates the speed wait succeeding from it timing out. Extra runs inject a start pulse mid-sequence, and the stuck indicator is driven with matching and non-matching state codes at both Gen1 and Gen2.

// File: rtl/pcie_speed_seq.sv
module pcie_speed_seq #(
  parameter int POLL_MAX    = 200,
  parameter int POLL_GAP    = 10000,
  parameter int TRAIN_RETRY = 5,
  parameter int RETRY_GAP   = 100000,
  parameter int RXRST_HOLD  = 200000,
  parameter int SPD_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             link_up_i,
  input  logic             in_train_i,
  input  logic             spd_pend_i,
  input  logic [5:0]       ltssm_state_i,
  input  logic             rx_valid_i,
  output logic [SPD_W-1:0] max_speed_o,
  output logic             ltssm_en_o,
  output logic             spd_req_o,
  output logic             rx_ovrd_data_o,
  output logic             rx_ovrd_pll_o,
  output logic             stuck_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam int TMAX0 = (POLL_GAP > RETRY_GAP) ? POLL_GAP : RETRY_GAP;
  localparam int TMAX  = (TMAX0 > RXRST_HOLD) ? TMAX0 : RXRST_HOLD;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam int RW    = $clog2(TRAIN_RETRY + 2);
  localparam logic [SPD_W-1:0] GEN1 = SPD_W'(1);
  localparam logic [SPD_W-1:0] GEN2 = SPD_W'(2);
  localparam logic [5:0] RCVR_LOCK = 6'h0D;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LCHK, ST_LWAIT, ST_SWAIT, ST_SCHK, ST_RCVR
  } state_t;

  state_t         st;
  logic [TW-1:0]  tmr;
  logic [PW-1:0]  polls;
  logic [RW-1:0]  rtry;
  logic           second;
  logic           ovrd;

  wire last_poll = (polls == PW'(POLL_MAX - 1));
  wire tmr_zero  = (tmr == '0);
  wire lnk_ok    = link_up_i && !in_train_i;
  wire lnk_retry = link_up_i && in_train_i && (rtry < RW'(TRAIN_RETRY));

  assign rx_ovrd_data_o = ovrd;
  assign rx_ovrd_pll_o  = ovrd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tmr         <= '0;
      polls       <= '0;
      rtry        <= '0;
      second      <= 1'b0;
      ovrd        <= 1'b0;
      max_speed_o <= GEN1;
      ltssm_en_o  <= 1'b0;
      spd_req_o   <= 1'b0;
      stuck_o     <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      fail_o  <= 1'b0;
      stuck_o <= ltssm_en_o && (max_speed_o == GEN2) &&
                 (ltssm_state_i == RCVR_LOCK) && !rx_valid_i;
      case (st)
        ST_IDLE: if (start_i) begin
          max_speed_o <= GEN1;
          ltssm_en_o  <= 1'b1;
          polls       <= '0;
          rtry        <= '0;
          second      <= 1'b0;
          st          <= ST_LCHK;
        end
        ST_LCHK: begin
          if (lnk_ok) begin
            rtry  <= '0;
            polls <= '0;
            if (second) begin
              done_o <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              max_speed_o <= GEN2;
              spd_req_o   <= 1'b1;
              tmr         <= TW'(POLL_GAP - 1);
              st          <= ST_SWAIT;
            end
          end else if (lnk_retry) begin
            rtry <= rtry + 1'b1;
            tmr  <= TW'(RETRY_GAP - 1);
            st   <= ST_LWAIT;
          end else begin
            rtry <= '0;
            if (last_poll) begin
              ovrd      <= 1'b1;
              spd_req_o <= 1'b0;
              tmr       <= TW'(RXRST_HOLD - 1);
              st        <= ST_RCVR;
            end else begin
              polls <= polls + 1'b1;
              tmr   <= TW'(POLL_GAP - 1);
              st    <= ST_LWAIT;
            end
          end
        end
        ST_LWAIT: begin
          if (tmr_zero) st <= ST_LCHK;
          else          tmr <= tmr - 1'b1;
        end
        ST_SWAIT: begin
          if (tmr_zero) st <= ST_SCHK;
          else          tmr <= tmr - 1'b1;
        end
        ST_SCHK: begin
          if (!spd_pend_i) begin
            spd_req_o <= 1'b0;
            second    <= 1'b1;
            polls     <= '0;
            rtry      <= '0;
            st        <= ST_LCHK;
          end else if (last_poll) begin
            ovrd      <= 1'b1;
            spd_req_o <= 1'b0;
            tmr       <= TW'(RXRST_HOLD - 1);
            st        <= ST_RCVR;
          end else begin
            polls <= polls + 1'b1;
            tmr   <= TW'(POLL_GAP - 1);
            st    <= ST_SWAIT;
          end
        end
        ST_RCVR: begin
          if (tmr_zero) begin
            ovrd       <= 1'b0;
            fail_o     <= 1'b1;
            ltssm_en_o <= 1'b0;
            spd_req_o  <= 1'b0;
            st         <= ST_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_gen1_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ltssm_en_o) |-> max_speed_o == GEN1);

  p_req_at_gen2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spd_req_o |-> max_speed_o == GEN2);

  p_ovrd_ends_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ovrd_data_o) |-> fail_o && !ltssm_en_o);

  p_stuck_gen2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_o |-> $past(max_speed_o) == GEN2);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> !(done_o || fail_o));

endmodule

// File: tb/pcie_speed_seq_tb_top.sv
module pcie_speed_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam int G = 3;
  localparam int T = 2;
  localparam int R = 2;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, link_up_i = 1'b0, in_train_i = 1'b0, spd_pend_i = 1'b0;
  logic [5:0] ltssm_state_i = 6'h00;
  logic rx_valid_i = 1'b1;
  logic [3:0] max_speed_o;
  logic ltssm_en_o, spd_req_o, rx_ovrd_data_o, rx_ovrd_pll_o, stuck_o, done_o, fail_o;

  int errors = 0;
  int checks = 0;
  int U, W, V;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_speed_seq #(.POLL_MAX(P), .POLL_GAP(G), .TRAIN_RETRY(T), .RETRY_GAP(R),
                   .RXRST_HOLD(H), .SPD_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_up_i(link_up_i),
    .in_train_i(in_train_i), .spd_pend_i(spd_pend_i), .ltssm_state_i(ltssm_state_i),
    .rx_valid_i(rx_valid_i), .max_speed_o(max_speed_o), .ltssm_en_o(ltssm_en_o),
    .spd_req_o(spd_req_o), .rx_ovrd_data_o(rx_ovrd_data_o), .rx_ovrd_pll_o(rx_ovrd_pll_o),
    .stuck_o(stuck_o), .done_o(done_o), .fail_o(fail_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (U=%0d W=%0d V=%0d)", req, act, exp, U, W, V);
    end
  endtask

  function automatic int lwait(input int t0, output bit ok);
    int t = t0;
    ok = 1'b0;
    for (int p = 1; p <= P; p++) begin
      int rt = 0;
      bit fin = 1'b0;
      while (!fin) begin
        if (t >= U && t >= W) begin ok = 1'b1; return t; end
        else if (t >= U && t < W && rt < T) begin rt++; t += R + 1; end
        else fin = 1'b1;
      end
      if (p == P) return t;
      t += G + 1;
    end
    return t;
  endfunction

  function automatic int swait(input int t0, output bit ok);
    int t = t0;
    ok = 1'b0;
    for (int j = 1; j <= P; j++) begin
      if (t >= V) begin ok = 1'b1; return t; end
      if (j == P) return t;
      t += G + 1;
    end
    return t;
  endfunction

  task automatic drive_for(input int n);
    link_up_i  = (n >= U);
    in_train_i = (n < W);
    spd_pend_i = (n < V);
  endtask

  task automatic run(input int u, input int w, input int v, input bit poke);
    bit ok1, ok2, ok3, exp_done;
    int w1, s, w2, exp_end, exp_gen2_from;
    int cnt = 0, ovrd_cnt = 0, spd_bad = 0, seen_done = 0, seen_fail = 0;
    U = u; W = w; V = v;
    w1 = lwait(1, ok1);
    exp_gen2_from = ok1 ? w1 : 100000;
    if (!ok1) begin exp_done = 0; exp_end = w1 + H; end
    else begin
      s = swait(w1 + G + 1, ok2);
      if (!ok2) begin exp_done = 0; exp_end = s + H; end
      else begin
        w2 = lwait(s + 1, ok3);
        exp_done = ok3;
        exp_end = ok3 ? w2 : w2 + H;
      end
    end
    @(negedge clk);
    start_i = 1'b1;
    drive_for(0);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    drive_for(1);
    while (cnt < 600) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (rx_ovrd_data_o && rx_ovrd_pll_o) ovrd_cnt++;
      if (max_speed_o != ((cnt < exp_gen2_from) ? 4'd1 : 4'd2)) spd_bad++;
      if (done_o || fail_o) begin
        seen_done = done_o;
        seen_fail = fail_o;
        break;
      end
      start_i = (poke && cnt == 2);
      drive_for(cnt + 1);
    end
    start_i = 1'b0;
    // R3 R4 R6 R9: outcome and edge of completion
    chk(cnt == exp_end, poke ? "R9 end edge with busy start" : "R3/R4 end edge", cnt, exp_end);
    chk(seen_done == int'(exp_done) && seen_fail == int'(!exp_done), "R6 outcome", seen_done, exp_done);
    chk(seen_done + seen_fail == 1, "R9 exclusive pulse", seen_done + seen_fail, 1);
    chk(spd_bad == 0, "R5 speed cap timing", spd_bad, 0);
    if (!exp_done) begin
      chk(ovrd_cnt == H, "R7 override width", ovrd_cnt, H);
      chk(!ltssm_en_o && !spd_req_o, "R7 enable cleared", ltssm_en_o, 0);
    end else begin
      chk(ltssm_en_o && !spd_req_o && max_speed_o == 4'd2, "R6 final state", max_speed_o, 2);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!done_o && !fail_o, "R9 single pulse", done_o | fail_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(max_speed_o == 4'd1, "R1 max speed", max_speed_o, 1);
    chk({ltssm_en_o, spd_req_o, rx_ovrd_data_o, rx_ovrd_pll_o, stuck_o, done_o, fail_o} == 7'b0,
        "R1 outputs low", ltssm_en_o, 0);
    // R2 start: gen1 and enable right after start edge
    U = 1000; W = 0; V = 0;
    start_i = 1'b1;
    drive_for(0);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(ltssm_en_o && max_speed_o == 4'd1, "R2 start state", max_speed_o, 1);
    while (!fail_o) begin @(posedge clk); @(negedge clk); end
    // sweeps over link-up, training-clear and pending-clear cycles
    for (int u = 0; u <= 24; u++) begin
      for (int wi = 0; wi < 3; wi++) begin
        for (int vi = 0; vi < 3; vi++) begin
          int w = (wi == 0) ? 0 : (wi == 1) ? u + 4 : 60;
          int v = (vi == 0) ? 0 : (vi == 1) ? 12 + u : 200;
          run(u, w, v, 1'b0);
        end
      end
    end
    for (int u = 0; u <= 8; u += 2) run(u, u + 3, 14, 1'b1);
    // R8 stuck indicator at Gen2 after a successful run
    run(0, 0, 0, 1'b0);
    ltssm_state_i = 6'h0D; rx_valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(stuck_o == 1'b1, "R8 stuck at gen2", stuck_o, 1);
    rx_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(stuck_o == 1'b0, "R8 rx valid clears", stuck_o, 0);
    ltssm_state_i = 6'h0C; rx_valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(stuck_o == 1'b0, "R8 other state", stuck_o, 0);
    ltssm_state_i = 6'h0D;
    run(1000, 0, 0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(stuck_o == 1'b0, "R8 disabled after fail", stuck_o, 0);
    ltssm_state_i = 6'h00; rx_valid_i = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule